// File: doc/BRIEF.md
# Synchronous serial slave receiver

This block is a receive-only serial port that takes its bit clock from an external master. The incoming clock and data lines are brought into the system clock domain through synchronizer flops. The receiver samples the data line on the rising edge of the effective clock, which is the incoming clock optionally inverted. Words of 8 or 9 bits are assembled least significant bit first and handed to a single-stage holding register. A receive-complete flag, an optional interrupt request and an overrun flag report each word's fate.

Control arrives as plain register bits: a port enable, a synchronous-mode bit, a clock-source select, clock inversion, 9-bit mode, continuous-receive enable and receive interrupt enable. A read strobe takes the held word. A sleep input leaves reception running and turns a completed word into a wake request. Errors are cleared only by dropping the continuous-receive enable, and the same action discards any partially received word.

Top module: `sync_slave_rx`

## Requirements
- R1: Words are assembled only while port_en_i=1, sync_mode_i=1, clk_src_i=0 and cont_rx_i=1; with any of these otherwise, clock edges complete no word.
- R2: Data is sampled on each rising edge of the effective clock, which is ser_clk_i when clk_inv_i=0 and its inverse when clk_inv_i=1, and the first bit received lands in bit 0.
- R3: With nine_bit_i=0 a word is 8 bits, presented on rx_data_o, and rx_bit8_o reads 0.
- R4: With nine_bit_i=1 a word is 9 bits; bits 0..7 go to rx_data_o and the ninth bit to rx_bit8_o.
- R5: A finished word is loaded into the holding register and rx_done_o rises on the 4th system clock edge after the final effective rising edge at the pin; a one-cycle rd_i pulse clears rx_done_o.
- R6: irq_o is high exactly while rx_done_o=1 and rx_ie_i=1.
- R7: single_rx_i has no effect on reception: it neither starts reception when cont_rx_i=0 nor alters it when cont_rx_i=1.
- R8: A word that finishes while rx_done_o=1 sets overrun_o and is discarded, leaving rx_data_o unchanged, and no further word completes while overrun_o=1, even after a read.
- R9: Driving cont_rx_i low clears overrun_o and drops any partial word, so the next word starts from its first bit.
- R10: With sleep_i=1, reception continues and wake_o is high while rx_done_o=1 and rx_ie_i=1; wake_o is low when sleep_i=0 or rx_ie_i=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | External serial bit clock |
| ser_dat_i | input | 1 | Serial data line |
| port_en_i | input | 1 | Port enable |
| sync_mode_i | input | 1 | Synchronous mode select |
| clk_src_i | input | 1 | Clock source select, 0 = external (slave) |
| clk_inv_i | input | 1 | Invert the incoming clock |
| nine_bit_i | input | 1 | 9-bit word mode |
| cont_rx_i | input | 1 | Continuous receive enable; low clears errors |
| single_rx_i | input | 1 | Single receive enable, ignored in this mode |
| rx_ie_i | input | 1 | Receive interrupt enable |
| sleep_i | input | 1 | System low-power indication |
| rd_i | input | 1 | Read strobe for the holding register |
| rx_data_o | output | 8 | Received data bits 0..7 |
| rx_bit8_o | output | 1 | Ninth received bit |
| rx_done_o | output | 1 | Receive-complete flag |
| overrun_o | output | 1 | Overrun error flag |
| irq_o | output | 1 | Receive interrupt request |
| wake_o | output | 1 | Wake request while sleeping |

## Verification
A pin transition costs two synchronizer cycles, one cycle to the edge detector and shifter, and one to the holding register, so rx_done_o is due on the fourth system clock edge after the last effective rising edge; the bench checks it low after three edges and high after four. Bench drive changes only on falling system clock edges, and each bit is held for four system cycles on either side of its clock edge, so the synchronized data is stable when sampled. A monitor compares each word against the scoreboard queue on the falling edge after rx_done_o rises and reads it one edge later; overrun, read clearing and wake are checked after the same fixed waits once the tail of the word has drained.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  typedef struct packed {
    logic port_en;
    logic sync_mode;
    logic clk_src;
    logic clk_inv;
    logic nine_bit;
    logic cont_rx;
    logic rx_ie;
  } rx_ctrl_t;

  function automatic logic rx_enabled(rx_ctrl_t c);
    return c.port_en & c.sync_mode & ~c.clk_src & c.cont_rx;
  endfunction
endpackage

// File: rtl/sync_rx_cdc.sv
module sync_rx_cdc #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg <= '0;
        else         stg <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg <= '0;
        else         stg <= {stg[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sync_rx_shift.sv
module sync_rx_shift #(
  parameter int DATA_W = 8,
  localparam int WORD_W = DATA_W + 1,
  localparam int CNT_W  = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              blk_i,
  input  logic              nine_i,
  input  logic              rise_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o
);
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sh, asm;
  logic [CNT_W-1:0]  last;

  assign last = nine_i ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);

  // fresh word starts from zero so unused upper bit reads 0
  always_comb begin
    asm      = (cnt == '0) ? '0 : sh;
    asm[cnt] = bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt    <= '0;
      sh     <= '0;
      word_o <= '0;
      done_o <= 1'b0;
    end else if (!en_i) begin
      cnt    <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (rise_i && !blk_i) begin
        if (cnt == last) begin
          word_o <= asm;
          done_o <= 1'b1;
          cnt    <= '0;
        end else begin
          sh  <= asm;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sync_rx_hold.sv
module sync_rx_hold #(
  parameter int WORD_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              cont_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] data_o,
  output logic              full_o,
  output logic              ovr_o
);
  logic busy;
  assign busy = full_o & ~rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
    end else if (done_i && !busy) begin
      data_o <= word_i;
      full_o <= 1'b1;
    end else if (rd_i) begin
      full_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ovr_o <= 1'b0;
    else if (!cont_i)         ovr_o <= 1'b0;
    else if (done_i && busy)  ovr_o <= 1'b1;
  end
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
  import sync_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              port_en_i,
  input  logic              sync_mode_i,
  input  logic              clk_src_i,
  input  logic              clk_inv_i,
  input  logic              nine_bit_i,
  input  logic              cont_rx_i,
  input  logic              single_rx_i,
  input  logic              rx_ie_i,
  input  logic              sleep_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_bit8_o,
  output logic              rx_done_o,
  output logic              overrun_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int WORD_W = DATA_W + 1;

  rx_ctrl_t ctrl;
  assign ctrl = '{port_en:   port_en_i,   sync_mode: sync_mode_i,
                  clk_src:   clk_src_i,   clk_inv:   clk_inv_i,
                  nine_bit:  nine_bit_i,  cont_rx:   cont_rx_i,
                  rx_ie:     rx_ie_i};

  // single receive has no role when clocked externally
  logic unused_single;
  assign unused_single = single_rx_i;

  logic [1:0] pin_s;
  sync_rx_cdc #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_cdc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ser_dat_i, ser_clk_i}),
    .q_o   (pin_s)
  );

  logic eff_ck, eff_q, bit_rise, port_active;
  assign eff_ck = pin_s[0] ^ ctrl.clk_inv;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) eff_q <= 1'b0;
    else         eff_q <= eff_ck;

  assign bit_rise    = eff_ck & ~eff_q;
  assign port_active = rx_enabled(ctrl);

  logic [WORD_W-1:0] word, held;
  logic              word_done, full, ovr;

  sync_rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (port_active),
    .blk_i (ovr),
    .nine_i(ctrl.nine_bit),
    .rise_i(bit_rise),
    .bit_i (pin_s[1]),
    .word_o(word),
    .done_o(word_done)
  );

  sync_rx_hold #(.WORD_W(WORD_W)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .done_i(word_done),
    .word_i(word),
    .cont_i(ctrl.cont_rx),
    .rd_i  (rd_i),
    .data_o(held),
    .full_o(full),
    .ovr_o (ovr)
  );

  assign rx_data_o = held[DATA_W-1:0];
  assign rx_bit8_o = held[DATA_W];
  assign rx_done_o = full;
  assign overrun_o = ovr;
  assign irq_o     = full & ctrl.rx_ie;
  assign wake_o    = full & ctrl.rx_ie & sleep_i;
endmodule

// File: rtl/sync_slave_rx_chk.sv
module sync_slave_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cont_rx_i,
  input logic              rd_i,
  input logic              rx_ie_i,
  input logic              sleep_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_done_o,
  input logic              overrun_o,
  input logic              wake_o,
  input logic              word_done_i
);
  assert_no_word_when_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cont_rx_i |=> !word_done_i);

  assert_done_follows_word_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_done_o) |-> $past(word_done_i));

  assert_read_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !word_done_i) |=> !rx_done_o);

  assert_held_data_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_o && !rd_i) |=> $stable(rx_data_o));

  assert_overrun_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && cont_rx_i) |=> overrun_o);

  assert_overrun_cleared_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cont_rx_i |=> !overrun_o);

  assert_wake_needs_sleep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (sleep_i && rx_ie_i && rx_done_o));
endmodule

bind sync_slave_rx sync_slave_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cont_rx_i  (cont_rx_i),
  .rd_i       (rd_i),
  .rx_ie_i    (rx_ie_i),
  .sleep_i    (sleep_i),
  .rx_data_o  (rx_data_o),
  .rx_done_o  (rx_done_o),
  .overrun_o  (overrun_o),
  .wake_o     (wake_o),
  .word_done_i(word_done)
);

// File: tb/tb_sync_slave_rx.sv
`timescale 1ns/1ps
module tb_sync_slave_rx;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ser_clk_i = 1'b0, ser_dat_i = 1'b0;
  logic port_en_i = 1'b1, sync_mode_i = 1'b1, clk_src_i = 1'b0, clk_inv_i = 1'b0;
  logic nine_bit_i = 1'b0, cont_rx_i = 1'b0, single_rx_i = 1'b0, rx_ie_i = 1'b1, sleep_i = 1'b0;
  logic rd_auto = 1'b0, rd_man = 1'b0, rd_i;
  logic [7:0] rx_data_o;
  logic rx_bit8_o, rx_done_o, overrun_o, irq_o, wake_o;
  logic auto_rd = 1'b1;
  logic [8:0] exp_q[$];
  int checks = 0, errors = 0;

  assign rd_i = rd_auto | rd_man;
  always #4 clk = ~clk;

  sync_slave_rx dut (
    .clk_i(clk), .rst_ni(rst_ni), .ser_clk_i(ser_clk_i), .ser_dat_i(ser_dat_i),
    .port_en_i(port_en_i), .sync_mode_i(sync_mode_i), .clk_src_i(clk_src_i),
    .clk_inv_i(clk_inv_i), .nine_bit_i(nine_bit_i), .cont_rx_i(cont_rx_i),
    .single_rx_i(single_rx_i), .rx_ie_i(rx_ie_i), .sleep_i(sleep_i), .rd_i(rd_i),
    .rx_data_o(rx_data_o), .rx_bit8_o(rx_bit8_o), .rx_done_o(rx_done_o),
    .overrun_o(overrun_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop expected word when a word is flagged, then read it
  initial forever begin
    @(negedge clk);
    if (auto_rd && rx_done_o && !rd_auto) begin
      if (exp_q.size() == 0) chk("R5 unexpected word", {rx_bit8_o, rx_data_o}, 9'h1ff);
      else chk("R2/R3/R4 word", {rx_bit8_o, rx_data_o}, exp_q.pop_front());
      chk("R6 irq on word", irq_o, rx_ie_i);
      rd_auto = 1'b1;
    end else rd_auto = 1'b0;
  end

  task automatic send_bits(input logic [8:0] w, input int n, input bit lat);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ser_clk_i = clk_inv_i;
      ser_dat_i = w[i];
      repeat (4) @(negedge clk);
      ser_clk_i = ~clk_inv_i;
      if (lat && i == n - 1) begin
        repeat (3) @(negedge clk);
        chk("R5 latency edge 3", rx_done_o, 1'b0);
        @(negedge clk);
        chk("R5 latency edge 4", rx_done_o, 1'b1);
      end else repeat (4) @(negedge clk);
    end
    ser_clk_i = clk_inv_i;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_word(input logic [8:0] w, input int n);
    exp_q.push_back(w);
    send_bits(w, n, 1'b0);
  endtask

  task automatic drained(input string req);
    repeat (20) @(negedge clk);
    chk(req, exp_q.size(), 0);
  endtask

  task automatic do_read(input string req, input logic [8:0] w);
    @(negedge clk);
    chk(req, rx_done_o, 1'b1);
    chk(req, {rx_bit8_o, rx_data_o}, w);
    rd_man = 1'b1;
    @(negedge clk);
    rd_man = 1'b0;
    chk("R5 read clears flag", rx_done_o, 1'b0);
  endtask

  task automatic restart_rx(input logic inv);
    @(negedge clk);
    cont_rx_i = 1'b0;
    clk_inv_i = inv;
    ser_clk_i = inv;
    repeat (8) @(negedge clk);
    cont_rx_i = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("reset rx_done", rx_done_o, 0);
    chk("reset overrun", overrun_o, 0);
    chk("reset irq R6", irq_o, 0);
    chk("reset wake R10", wake_o, 0);
    chk("reset data", {rx_bit8_o, rx_data_o}, 0);

    // R2 R3 R6: 8-bit, normal polarity
    restart_rx(1'b0);
    send_word(9'h0a5, 8);
    send_word(9'h03c, 8);
    rx_ie_i = 1'b0;
    send_word(9'h0c3, 8);
    rx_ie_i = 1'b1;
    drained("R3 8-bit words drained");

    // R2 inverted clock
    restart_rx(1'b1);
    send_word(9'h096, 8);
    drained("R2 inverted clock drained");
    restart_rx(1'b0);

    // R4 9-bit
    nine_bit_i = 1'b1;
    send_word(9'h15a, 9);
    send_word(9'h0ff, 9);
    send_word(9'h101, 9);
    drained("R4 9-bit drained");
    nine_bit_i = 1'b0;

    // R7 single receive alone does nothing
    @(negedge clk);
    cont_rx_i = 1'b0;
    single_rx_i = 1'b1;
    send_bits(9'h0e1, 8, 1'b0);
    chk("R7 single_rx without cont_rx", rx_done_o, 0);
    cont_rx_i = 1'b1;
    send_word(9'h033, 8);
    drained("R7 single_rx with cont_rx");
    single_rx_i = 1'b0;

    // R1 master clock source blocks reception
    clk_src_i = 1'b1;
    send_bits(9'h0f0, 8, 1'b0);
    chk("R1 clk_src set", rx_done_o, 0);
    clk_src_i = 1'b0;
    port_en_i = 1'b0;
    send_bits(9'h00f, 8, 1'b0);
    chk("R1 port disabled", rx_done_o, 0);
    port_en_i = 1'b1;
    send_word(9'h081, 8);
    drained("R1 port enabled again");

    // R8 overrun
    auto_rd = 1'b0;
    send_bits(9'h04b, 8, 1'b1);
    chk("R6 irq held word", irq_o, 1);
    send_bits(9'h0d2, 8, 1'b0);
    chk("R8 overrun set", overrun_o, 1);
    chk("R8 data kept", rx_data_o, 8'h4b);
    do_read("R8 read after overrun", 9'h04b);
    send_bits(9'h077, 8, 1'b0);
    chk("R8 blocked after overrun", rx_done_o, 0);
    chk("R8 overrun still set", overrun_o, 1);
    @(negedge clk);
    cont_rx_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 overrun cleared", overrun_o, 0);
    cont_rx_i = 1'b1;
    auto_rd = 1'b1;
    send_word(9'h06c, 8);
    drained("R9 receive after clear");

    // R9 partial word dropped
    send_bits(9'h005, 3, 1'b0);
    @(negedge clk);
    cont_rx_i = 1'b0;
    repeat (4) @(negedge clk);
    cont_rx_i = 1'b1;
    send_word(9'h05e, 8);
    drained("R9 partial dropped");

    // R10 sleep and wake
    auto_rd = 1'b0;
    sleep_i = 1'b1;
    send_bits(9'h03a, 8, 1'b0);
    chk("R10 wake with ie", wake_o, 1);
    do_read("R10 word in sleep", 9'h03a);
    chk("R10 wake cleared", wake_o, 0);
    rx_ie_i = 1'b0;
    send_bits(9'h0c5, 8, 1'b0);
    chk("R10 no wake without ie", wake_o, 0);
    chk("R6 no irq without ie", irq_o, 0);
    do_read("R10 word in sleep no ie", 9'h0c5);
    sleep_i = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule